// File: doc/BRIEF.md
# Interval Timer with Pulse Counting

This block is a 16-bit down-counter. It runs in one of two modes, chosen by a mode input. In interval mode it steps down once per system clock. In pulse-count mode it steps down once per falling edge seen on an external pulse pin. The counter is loaded in two steps. A write to the low byte only updates a holding latch. A write to the high byte moves the high byte and the latch into the counter, which restarts it.

When the counter is decremented while it reads zero, it times out. The counter then wraps and keeps counting, so software can read back the time or the count since the timeout. Each timeout gives a one-cycle strobe. In the same cycle an interrupt-set pulse is given, but only for the first timeout after a start. When an external two-bit shift-mode field selects timer-driven shifting, each timeout also gives a shift-clock strobe, and the counter's low byte is reloaded from the latch.

Top module: `pulse_interval_timer`

## Requirements
- R1: After reset the counter reads 0x0000, `irq_flag`, `irq_set`, `tmo_strobe` and `shift_clk` are 0, and no interrupt can occur before the first high-byte write. A timeout that happens before any start strobes `tmo_strobe` with `irq_set` low.
- R2: A `wr_lo` cycle stores `wr_data` in the low latch and leaves the counter counting as before. A `wr_hi` cycle makes the counter read {`wr_data`, latch} one cycle later, and in that same cycle it clears `irq_flag`.
- R3: With `count_pulses`=0 the counter decrements every clock. When the write of value N is sampled at edge k, `tmo_strobe` is high for exactly one cycle, after edge k+N+1.
- R4: With `count_pulses`=1 the counter changes only at an edge where `pb_in` is 0 and its sample from the previous cycle was 1. A level held at 0 or at 1 leaves it unchanged.
- R5: At the first edge after `count_pulses` switches from 0 to 1, the counter does not decrement, even if `pb_in` falls at that edge.
- R6: `irq_set` is high in the same cycle as `tmo_strobe`, but only for the first timeout after each high-byte write. `irq_flag` becomes 1 with it and stays 1 until the next high-byte write.
- R7: In both modes, after a timeout the counter wraps to 0xFFFF and keeps decrementing at its mode's rate.
- R8: When `shift_sel` equals 2'b01, each timeout raises `shift_clk` together with `tmo_strobe`, and the counter becomes {0xFF, latch}. For any other `shift_sel` value, `shift_clk` stays 0.
- R9: When a high-byte write and a timeout fall in the same cycle, the write wins. No strobe is produced, and timing restarts from the newly written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_lo | input | 1 | Write `wr_data` to the low latch |
| wr_hi | input | 1 | Write the high byte, load the counter and start it |
| wr_data | input | 8 | Write data |
| count_pulses | input | 1 | 1 = count falling edges of `pb_in`, 0 = count clocks |
| pb_in | input | 1 | External pulse input, already synchronous |
| shift_sel | input | 2 | Shift-mode field; 2'b01 selects timer-driven shifting |
| cnt_q | output | 16 | Counter readback |
| irq_set | output | 1 | One-cycle interrupt-set pulse |
| irq_flag | output | 1 | Interrupt flag level |
| tmo_strobe | output | 1 | One-cycle timeout strobe |
| shift_clk | output | 1 | One-cycle shift-clock strobe |

## Verification
Counter readback changes one cycle after the edge that samples a write, a clock step or a pulse edge. In interval mode the timeout strobes follow N+2 cycles after the high-byte write is driven. In pulse-count mode they follow one cycle after the falling edge is driven. The driver tasks record the bench cycle at which each stimulus is applied and push the cycle in which the strobes are due, together with the expected interrupt and shift-clock values. On every falling clock edge the monitor compares that queue with the outputs. It reports a strobe that arrives late, early or without being expected. Readback checks wait until the exact cycle computed for each value.

// File: rtl/pulse_interval_timer.sv
module pulse_interval_timer #(
  parameter int CNT_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_lo,
  input  logic                 wr_hi,
  input  logic [CNT_W/2-1:0]   wr_data,
  input  logic                 count_pulses,
  input  logic                 pb_in,
  input  logic [1:0]           shift_sel,
  output logic [CNT_W-1:0]     cnt_q,
  output logic                 irq_set,
  output logic                 irq_flag,
  output logic                 tmo_strobe,
  output logic                 shift_clk
);
  localparam int BYTE_W = CNT_W / 2;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [BYTE_W-1:0] latch_lo;
  logic [CNT_W-1:0]  cnt;
  logic              fired, pb_prev, mode_prev;
  logic              tmo_q, irq_q, sh_q, flag_q;

  wire fall     = pb_prev & ~pb_in;
  wire step     = count_pulses ? (fall & mode_prev) : 1'b1;
  wire hit      = step & (cnt == '0) & ~wr_hi;
  wire shift_on = (shift_sel == 2'b01);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latch_lo  <= '0;
      cnt       <= '0;
      fired     <= 1'b1;
      pb_prev   <= 1'b1;
      mode_prev <= 1'b0;
      tmo_q     <= 1'b0;
      irq_q     <= 1'b0;
      sh_q      <= 1'b0;
      flag_q    <= 1'b0;
    end else begin
      pb_prev   <= pb_in;
      mode_prev <= count_pulses;
      tmo_q     <= hit;
      irq_q     <= hit & ~fired;
      sh_q      <= hit & shift_on;
      if (wr_lo) latch_lo <= wr_data;
      if (wr_hi) begin
        cnt    <= {wr_data, latch_lo};
        fired  <= 1'b0;
        flag_q <= 1'b0;
      end else if (hit) begin
        fired <= 1'b1;
        if (!fired) flag_q <= 1'b1;
        cnt <= shift_on ? {{BYTE_W{1'b1}}, latch_lo} : '1;
      end else if (step) begin
        cnt <= cnt - ONE;
      end
    end
  end

  assign cnt_q      = cnt;
  assign irq_set    = irq_q;
  assign irq_flag   = flag_q;
  assign tmo_strobe = tmo_q;
  assign shift_clk  = sh_q;

  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> (cnt_q == {$past(wr_data), $past(latch_lo)}) && !irq_flag); // R2
  AST_PULSE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (count_pulses && !wr_hi && !(pb_prev && !pb_in)) |=> $stable(cnt_q)); // R4
  AST_SWITCH_NO_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (count_pulses && !mode_prev && !wr_hi) |=> $stable(cnt_q)); // R5
  AST_IRQ_WITH_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |-> tmo_strobe && irq_flag); // R6
  AST_WRAP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    tmo_strobe |-> cnt_q[CNT_W-1:BYTE_W] == '1); // R7
  AST_SHIFT_WITH_TMO: assert property (@(posedge clk) disable iff (!rst_n)
    shift_clk |-> tmo_strobe); // R8
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hi |=> !tmo_strobe); // R9
endmodule

// File: tb/tb_pulse_interval_timer.sv
module tb_pulse_interval_timer;
  logic        clk = 0, rst_n = 0;
  logic        wr_lo = 0, wr_hi = 0, count_pulses = 1, pb_in = 1;
  logic [7:0]  wr_data = 0;
  logic [1:0]  shift_sel = 0;
  logic [15:0] cnt_q;
  logic        irq_set, irq_flag, tmo_strobe, shift_clk;

  pulse_interval_timer dut (.*);

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { int cyc; bit irq; bit sh; } ev_t;
  ev_t expq[$];
  int nchk = 0, nbad = 0;
  bit done = 0;

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %0h expected %0h (cycle %0d)", r, act, exp, cyc);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (expq.size() > 0 && expq[0].cyc < cyc) begin
      chk("R3 missed timeout strobe", 0, 1);
      void'(expq.pop_front());
    end
    if (expq.size() > 0 && expq[0].cyc == cyc) begin
      ev_t e;
      e = expq.pop_front();
      chk("R3 tmo_strobe", tmo_strobe, 1);
      chk("R6 irq_set", irq_set, e.irq);
      chk("R8 shift_clk", shift_clk, e.sh);
    end else if (tmo_strobe || irq_set || shift_clk) begin
      chk("R3 unexpected strobe", {tmo_strobe, irq_set, shift_clk}, 0);
    end
  end

  task automatic wait_to(int t);
    while (cyc < t) @(negedge clk);
  endtask
  task automatic write_lo(logic [7:0] b);
    wr_lo = 1; wr_data = b; @(negedge clk); wr_lo = 0;
  endtask
  task automatic write_hi(logic [7:0] b, output int c);
    wr_hi = 1; wr_data = b; c = cyc; @(negedge clk); wr_hi = 0;
  endtask
  task automatic pulse();
    pb_in = 0; @(negedge clk); pb_in = 1; @(negedge clk);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nchk++; nbad++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    int c, c2, v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 reset cnt", cnt_q, 0);
    chk("R1 reset irq_flag", irq_flag, 0);
    @(negedge clk);
    chk("R1 idle cnt in pulse mode", cnt_q, 0);
    // R1: timeout before any start gives no interrupt
    count_pulses = 0;
    expq.push_back('{cyc + 1, 1'b0, 1'b0});
    @(negedge clk);
    chk("R1 no flag before start", irq_flag, 0);
    chk("R7 wrap after pre-start timeout", cnt_q, 16'hFFFF);

    // R3 interval mode, N=5
    write_lo(8'd5); write_hi(8'd0, c);
    expq.push_back('{c + 7, 1'b1, 1'b0});
    chk("R2 load value", cnt_q, 5);
    wait_to(c + 7);
    chk("R7 wrap interval", cnt_q, 16'hFFFF);
    chk("R6 flag set", irq_flag, 1);
    repeat (3) @(negedge clk);
    chk("R7 keeps counting", cnt_q, 16'hFFFC);

    // R2 restart clears flag; low write mid-count does not disturb
    write_lo(8'd10); write_hi(8'd0, c);
    expq.push_back('{c + 12, 1'b1, 1'b0});
    chk("R2 flag cleared by high write", irq_flag, 0);
    chk("R2 load value 10", cnt_q, 10);
    write_lo(8'h77);
    chk("R2 low write leaves counter", cnt_q, 9);
    wait_to(c + 13);

    // R8 shift mode
    shift_sel = 2'b01;
    write_lo(8'd3); write_hi(8'd0, c);
    expq.push_back('{c + 5, 1'b1, 1'b1});
    wait_to(c + 5);
    chk("R8 low byte reload", cnt_q, 16'hFF03);
    shift_sel = 2'b10;
    @(negedge clk);

    // R9 high write wins over pending timeout
    write_lo(8'd0); write_hi(8'd0, c); write_hi(8'd0, c2);
    expq.push_back('{c2 + 2, 1'b1, 1'b0});
    wait_to(c2 + 3);
    chk("R9 single strobe then flag", irq_flag, 1);

    // R4 pulse-count mode
    count_pulses = 1;
    repeat (2) @(negedge clk);
    write_lo(8'd2); write_hi(8'd0, c);
    repeat (5) @(negedge clk);
    chk("R4 no edges no change", cnt_q, 2);
    pulse(); pulse();
    chk("R4 two edges", cnt_q, 0);
    expq.push_back('{cyc + 1, 1'b1, 1'b0});
    pulse();
    chk("R7 wrap pulse mode", cnt_q, 16'hFFFF);
    pulse();
    chk("R7 pulse after wrap", cnt_q, 16'hFFFE);

    // R5 mode switch with coincident falling edge
    count_pulses = 0;
    repeat (3) @(negedge clk);
    v = cnt_q;
    count_pulses = 1; pb_in = 0;
    @(negedge clk);
    chk("R5 no spurious edge", cnt_q, v);
    repeat (3) @(negedge clk);
    chk("R4 held low no change", cnt_q, v);
    pb_in = 1; @(negedge clk);
    pulse();
    chk("R4 edge after switch", cnt_q, v - 1);

    // R6 once per start across a full wrap
    count_pulses = 0;
    write_lo(8'd0); write_hi(8'd0, c);
    expq.push_back('{c + 2, 1'b1, 1'b0});
    expq.push_back('{c + 2 + 65536, 1'b0, 1'b0});
    wait_to(c + 4 + 65536);
    chk("R6 flag stays set", irq_flag, 1);
    chk("R3 all strobes seen", expq.size(), 0);
    done = 1;
    report();
  end
endmodule